// File: doc/BRIEF.md
# PATA PIO Timing Engine With One Shared Fast Bank

This block drives the PIO cycles of one legacy parallel ATA channel that carries a master and a slave drive. A host bus request that hits the channel's command block or control port becomes a read or write strobe toward the drives. The strobe length, the drive ready (IORDY) wait and the recovery gap come from a 16-bit timing control register.

There is one programmable fast timing bank. Both drives share it, and each drive opts in through its own fast bit. A data port access to a drive that has opted in uses the bank's sample point and recovery counts, in clocks. Every other access uses fixed compatible timing, which is safe for the slowest PIO mode. The target drive is tracked by shadowing the drive-select bit that the host writes to the device/head register.

Software writes the timing register through a simple configuration port. Host cycles use a request/ready handshake. The host holds the request until ready pulses. Requests that arrive during recovery wait until the engine is idle again.

Top module: `pata_pio_timer`

## Requirements
- R1: After reset the timing register reads 0x0000. While bit 15 is clear, no request produces a strobe or a ready pulse.
- R2: With bit 14 clear the block answers at 0x1F0..0x1F7 with the command select low and at 0x3F6 with the control select low. The control port drives the drive address as 6. With bit 14 set the addresses are 0x170..0x177 and 0x376 instead. irqSel follows bit 14 (0 selects IRQ 14, 1 selects IRQ 15). Requests to any other address get no strobe and no ready.
- R3: A write to command offset 6 stores its data bit 4 as the target drive (0 = drive 0, 1 = drive 1). Drive 0 uses register bits 3:0 and drive 1 uses bits 7:4. An ignored request leaves the target drive unchanged.
- R4: A data port (offset 0) access whose target drive has nibble bit 0 set holds the strobe low for (bits 13:12) + 2 clocks. It is followed by (bits 9:8) + 1 clocks of recovery.
- R5: Every other access uses compatible timing: a strobe of 8 clocks and a recovery of 10 clocks, whatever the bank fields hold. This covers a data port access whose target drive has fast bit 0 clear, and any access to a non-data register.
- R6: Once the strobe count has elapsed, the strobe stays low while IORDY is low. This applies to fast accesses with nibble bit 1 set and to all compatible accesses. A fast access with nibble bit 1 clear ignores IORDY.
- R7: reqReady is high for exactly one clock, in the first clock after the strobe's last low clock. On a read, rspRdata holds the drive data in that clock. On a write, ideDataOe is high and ideDataOut carries the write data while the strobe is low.
- R8: A request held during recovery is stalled. The next strobe starts after exactly the recovery count of clocks following the ready clock.
- R9: prefetchEn is high during the strobe of a data port access whose target drive has nibble bit 2 set. It is low for any other access.
- R10: cfgRdata returns the last value written through cfgWe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Timing register write enable |
| cfgWdata | input | 16 | Timing register write data |
| cfgRdata | output | 16 | Timing register contents |
| reqValid | input | 1 | Host request, held until ready |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Host I/O address |
| reqWdata | input | 16 | Host write data |
| reqReady | output | 1 | One-clock completion pulse |
| rspRdata | output | 16 | Read data, valid with reqReady |
| ideAddr | output | 3 | Drive register address |
| ideCs0N | output | 1 | Command block select, active low |
| ideCs1N | output | 1 | Control block select, active low |
| ideRdN | output | 1 | Read strobe, active low |
| ideWrN | output | 1 | Write strobe, active low |
| ideDataOut | output | 16 | Write data to drives |
| ideDataOe | output | 1 | Write data output enable |
| ideDataIn | input | 16 | Read data from drives |
| iordy | input | 1 | Drive ready, low stretches the strobe |
| prefetchEn | output | 1 | Prefetch/posting allowed for the current cycle |
| irqSel | output | 1 | Channel IRQ select (0 = IRQ 14, 1 = IRQ 15) |

## Verification
The bench counts the strobe-low clocks and the recovery clocks of back-to-back requests. It does this for both fast codes and compatible timing. A design with an off-by-one in either counter, or one that accepts a stalled request early, would show a wrong count.

It moves the drive select between drives that have different nibbles. It also sends an ignored write to the other channel's device/head address. A design that reads the wrong nibble, or that lets an undecoded write touch the shadow, would give a data access the wrong timing.

It holds IORDY low past the sample point in each of three cases: fast with IORDY enabled, fast with IORDY disabled, and compatible. This catches a strobe that ignores IORDY, or one that waits on it when it should not.

It also probes the disabled state and the opposite channel's addresses. A faulty decode would produce strobes there.

// File: rtl/pata_pio_pkg.sv
package pata_pio_pkg;
  localparam int REG_W = 16;

  typedef struct packed {
    logic accept;
    logic capture;
    logic strobeOn;
  } ctrlStrobes_t;
endpackage

// File: rtl/pata_pio_ctrl.sv
module pata_pio_ctrl
  import pata_pio_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hit,
  input  logic [CNT_W-1:0] strobeLen,
  input  logic [CNT_W-1:0] recovLen,
  input  logic             useRdy,
  input  logic             iordy,
  output ctrlStrobes_t     strobes,
  output logic             ready
);
  typedef enum logic [1:0] {ST_IDLE, ST_STROBE, ST_RECOV} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] recQ;
  logic             rdyQ;
  logic             done;

  always_comb begin
    done             = (state == ST_STROBE) && (cnt == '0) && (!rdyQ || iordy);
    strobes.accept   = (state == ST_IDLE) && hit;
    strobes.capture  = done;
    strobes.strobeOn = (state == ST_STROBE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      recQ  <= '0;
      rdyQ  <= 1'b0;
      ready <= 1'b0;
    end else begin
      ready <= done;
      case (state)
        ST_IDLE: begin
          if (strobes.accept) begin
            state <= ST_STROBE;
            cnt   <= strobeLen - CNT_W'(1);
            recQ  <= recovLen - CNT_W'(1);
            rdyQ  <= useRdy;
          end
        end
        ST_STROBE: begin
          if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
          end else if (done) begin
            state <= ST_RECOV;
            cnt   <= recQ;
          end
        end
        default: begin
          if (cnt != '0) cnt <= cnt - CNT_W'(1);
          else state <= ST_IDLE;
        end
      endcase
    end
  end

  // R7: the completion pulse lasts a single clock
  assert_ready_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> !ready);

  // R7: ready comes in the clock where the strobe has just been released
  assert_ready_on_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobes.strobeOn) |-> ready);

  // R8: recovery keeps the strobe off right after release
  assert_recovery_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobes.strobeOn) |=> !strobes.strobeOn);

  // R6: a low IORDY at the sample point stretches the strobe
  assert_iordy_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.strobeOn && cnt == '0 && rdyQ && !iordy) |=> strobes.strobeOn);
endmodule

// File: rtl/pata_pio_dp.sv
module pata_pio_dp
  import pata_pio_pkg::*;
#(
  parameter int          CNT_W         = 4,
  parameter int          ADDR_W        = 16,
  parameter int          DATA_W        = 16,
  parameter int          COMPAT_STROBE = 8,
  parameter int          COMPAT_RECOV  = 10,
  parameter logic [15:0] PRI_CMD       = 16'h01F0,
  parameter logic [15:0] PRI_CTL       = 16'h03F6,
  parameter logic [15:0] SEC_CMD       = 16'h0170,
  parameter logic [15:0] SEC_CTL       = 16'h0376
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [REG_W-1:0]  cfgWdata,
  output logic [REG_W-1:0]  cfgRdata,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rspRdata,
  input  ctrlStrobes_t      strobes,
  output logic              hit,
  output logic [CNT_W-1:0]  strobeLen,
  output logic [CNT_W-1:0]  recovLen,
  output logic              useRdy,
  output logic [2:0]        ideAddr,
  output logic              ideCs0N,
  output logic              ideCs1N,
  output logic              ideRdN,
  output logic              ideWrN,
  output logic [DATA_W-1:0] ideDataOut,
  output logic              ideDataOe,
  input  logic [DATA_W-1:0] ideDataIn,
  output logic              prefetchEn,
  output logic              irqSel
);
  logic [REG_W-1:0]  timReg;
  logic              driveSel;
  logic [ADDR_W-1:0] cmdBase, ctlAddr;
  logic              hitCmd, hitCtl, isData, useFast;
  logic [3:0]        nibble;
  logic              curWrite, curCmd, curPf;
  logic [2:0]        curAddr;
  logic [DATA_W-1:0] curWdata;

  always_comb begin
    cmdBase   = timReg[14] ? ADDR_W'(SEC_CMD) : ADDR_W'(PRI_CMD);
    ctlAddr   = timReg[14] ? ADDR_W'(SEC_CTL) : ADDR_W'(PRI_CTL);
    hitCmd    = timReg[15] && (reqAddr[ADDR_W-1:3] == cmdBase[ADDR_W-1:3]);
    hitCtl    = timReg[15] && (reqAddr == ctlAddr);
    hit       = reqValid && (hitCmd || hitCtl);
    nibble    = driveSel ? timReg[7:4] : timReg[3:0];
    isData    = hitCmd && (reqAddr[2:0] == 3'd0);
    useFast   = isData && nibble[0];
    strobeLen = useFast ? CNT_W'(timReg[13:12]) + CNT_W'(2) : CNT_W'(COMPAT_STROBE);
    recovLen  = useFast ? CNT_W'(timReg[9:8]) + CNT_W'(1) : CNT_W'(COMPAT_RECOV);
    useRdy    = useFast ? nibble[1] : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timReg   <= '0;
      driveSel <= 1'b0;
      curWrite <= 1'b0;
      curCmd   <= 1'b0;
      curPf    <= 1'b0;
      curAddr  <= '0;
      curWdata <= '0;
      rspRdata <= '0;
    end else begin
      if (cfgWe) timReg <= cfgWdata;
      if (strobes.accept) begin
        curWrite <= reqWrite;
        curCmd   <= hitCmd;
        curAddr  <= hitCmd ? reqAddr[2:0] : 3'd6;
        curWdata <= reqWdata;
        curPf    <= isData && nibble[2];
        if (reqWrite && hitCmd && reqAddr[2:0] == 3'd6) driveSel <= reqWdata[4];
      end
      if (strobes.capture && !curWrite) rspRdata <= ideDataIn;
    end
  end

  always_comb begin
    cfgRdata   = timReg;
    irqSel     = timReg[14];
    ideAddr    = curAddr;
    ideCs0N    = !(strobes.strobeOn && curCmd);
    ideCs1N    = !(strobes.strobeOn && !curCmd);
    ideRdN     = !(strobes.strobeOn && !curWrite);
    ideWrN     = !(strobes.strobeOn && curWrite);
    ideDataOut = curWdata;
    ideDataOe  = strobes.strobeOn && curWrite;
    prefetchEn = strobes.strobeOn && curPf;
  end

  // R1: nothing is accepted while the function is disabled
  assert_disabled_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accept |-> timReg[15]);

  // R2: a strobed cycle selects exactly one block
  assert_one_select_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.strobeOn |-> (ideCs0N != ideCs1N));
endmodule

// File: rtl/pata_pio_timer.sv
module pata_pio_timer
  import pata_pio_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 16,
  parameter int COMPAT_STROBE = 8,
  parameter int COMPAT_RECOV  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [REG_W-1:0]  cfgWdata,
  output logic [REG_W-1:0]  cfgRdata,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic [DATA_W-1:0] rspRdata,
  output logic [2:0]        ideAddr,
  output logic              ideCs0N,
  output logic              ideCs1N,
  output logic              ideRdN,
  output logic              ideWrN,
  output logic [DATA_W-1:0] ideDataOut,
  output logic              ideDataOe,
  input  logic [DATA_W-1:0] ideDataIn,
  input  logic              iordy,
  output logic              prefetchEn,
  output logic              irqSel
);
  localparam int MAX_A   = (COMPAT_STROBE > COMPAT_RECOV) ? COMPAT_STROBE : COMPAT_RECOV;
  localparam int MAX_LEN = (MAX_A > 5) ? MAX_A : 5;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  ctrlStrobes_t     strobes;
  logic             hit, useRdy;
  logic [CNT_W-1:0] strobeLen, recovLen;

  pata_pio_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hit(hit), .strobeLen(strobeLen),
    .recovLen(recovLen), .useRdy(useRdy), .iordy(iordy),
    .strobes(strobes), .ready(reqReady)
  );

  pata_pio_dp #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .COMPAT_STROBE(COMPAT_STROBE), .COMPAT_RECOV(COMPAT_RECOV)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspRdata(rspRdata),
    .strobes(strobes), .hit(hit), .strobeLen(strobeLen),
    .recovLen(recovLen), .useRdy(useRdy), .ideAddr(ideAddr),
    .ideCs0N(ideCs0N), .ideCs1N(ideCs1N), .ideRdN(ideRdN),
    .ideWrN(ideWrN), .ideDataOut(ideDataOut), .ideDataOe(ideDataOe),
    .ideDataIn(ideDataIn), .prefetchEn(prefetchEn), .irqSel(irqSel)
  );
endmodule

// File: tb/pata_pio_timer_bench.sv
module pata_pio_timer_bench;
  localparam int CS_LEN = 8;
  localparam int CR_LEN = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [15:0] cfgWdata = '0;
  logic [15:0] cfgRdata;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0, reqWdata = '0;
  logic        reqReady;
  logic [15:0] rspRdata;
  logic [2:0]  ideAddr;
  logic        ideCs0N, ideCs1N, ideRdN, ideWrN, ideDataOe;
  logic [15:0] ideDataOut;
  logic [15:0] ideDataIn = 16'hA5C3;
  logic        iordy = 1'b1;
  logic        prefetchEn, irqSel;

  int nChecks = 0;
  int nFails = 0;

  int          low, pre;
  logic [15:0] rd;
  logic [2:0]  adr;
  logic        c0, c1, pf, wok;

  pata_pio_timer u_pata_pio_timer (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspRdata(rspRdata), .ideAddr(ideAddr), .ideCs0N(ideCs0N),
    .ideCs1N(ideCs1N), .ideRdN(ideRdN), .ideWrN(ideWrN),
    .ideDataOut(ideDataOut), .ideDataOe(ideDataOe), .ideDataIn(ideDataIn),
    .iordy(iordy), .prefetchEn(prefetchEn), .irqSel(irqSel)
  );

  always #10 clk = ~clk;

  initial begin
    #2000000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic setReg(input logic [15:0] v);
    @(negedge clk);
    cfgWe = 1'b1;
    cfgWdata = v;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // Runs one host cycle; returns at the negedge where ready is seen.
  task automatic runCycle(input bit wr, input logic [15:0] addr, input logic [15:0] wdata,
                          input int releaseAt, input bit keep);
    bit got = 1'b0;
    low = 0; pre = 0; rd = '0; adr = '0; c0 = 1'b1; c1 = 1'b1; pf = 1'b0; wok = 1'b0;
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wdata;
    iordy = (releaseAt > 0) ? 1'b0 : 1'b1;
    for (int i = 0; i < 80 && !got; i++) begin
      @(negedge clk);
      if (!ideRdN || !ideWrN) begin
        if (low == 0) begin
          adr = ideAddr; c0 = ideCs0N; c1 = ideCs1N; pf = prefetchEn;
          wok = ideDataOe && (ideDataOut == wdata);
        end
        low++;
        if (low == releaseAt) iordy = 1'b1;
      end else if (low == 0) begin
        pre++;
      end
      if (reqReady) begin
        rd = rspRdata;
        got = 1'b1;
      end
    end
    if (!got) low = -1;
    if (!keep) reqValid = 1'b0;
    iordy = 1'b1;
  endtask

  task automatic ignoredReq(input string tag, input bit wr, input logic [15:0] addr,
                            input logic [15:0] wdata);
    int seen = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wdata;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!ideRdN || !ideWrN || reqReady) seen++;
    end
    reqValid = 1'b0;
    chk(tag, seen, 0);
  endtask

  task automatic testReset();
    chk("R1 reset register", cfgRdata, 16'h0000);
    chk("R1 reset strobes", {ideRdN, ideWrN, reqReady}, 3'b110);
    ignoredReq("R1 disabled request ignored", 1'b0, 16'h01F0, 16'h0);
  endtask

  task automatic testPrimary();
    setReg(16'h8000);
    chk("R10 register readback", cfgRdata, 16'h8000);
    chk("R2 irq select primary", irqSel, 0);
    ideDataIn = 16'hA5C3;
    runCycle(1'b0, 16'h01F7, 16'h0, 0, 1'b1);
    chk("R5 compat strobe length", low, CS_LEN);
    chk("R2 command select", {c0, c1, adr}, {1'b0, 1'b1, 3'd7});
    chk("R7 read data with ready", rd, 16'hA5C3);
    runCycle(1'b0, 16'h03F6, 16'h0, 0, 1'b0);
    chk("R8 compat recovery stall", pre, CR_LEN);
    chk("R2 control select", {c0, c1, adr}, {1'b1, 1'b0, 3'd6});
    chk("R5 control strobe length", low, CS_LEN);
    ignoredReq("R2 secondary command ignored", 1'b0, 16'h0170, 16'h0);
    ignoredReq("R2 secondary control ignored", 1'b0, 16'h0376, 16'h0);
    ignoredReq("R2 outside window ignored", 1'b0, 16'h01F8, 16'h0);
  endtask

  task automatic testSecondary();
    setReg(16'hC000);
    chk("R2 irq select secondary", irqSel, 1);
    runCycle(1'b1, 16'h0176, 16'h00E0, 0, 1'b0);
    chk("R2 secondary write strobe", low, CS_LEN);
    chk("R2 secondary address", {c0, adr}, {1'b0, 3'd6});
    chk("R7 write data on bus", wok, 1);
    ignoredReq("R2 primary ignored when secondary", 1'b0, 16'h01F0, 16'h0);
  endtask

  task automatic testFast();
    setReg(16'h9007);
    runCycle(1'b0, 16'h01F0, 16'h0, 0, 1'b1);
    chk("R4 fast strobe code 1", low, 3);
    chk("R9 prefetch on data port", pf, 1);
    runCycle(1'b0, 16'h01F0, 16'h0, 0, 1'b0);
    chk("R8 fast recovery code 0", pre, 1);
    chk("R4 fast strobe repeat", low, 3);
    setReg(16'hA307);
    runCycle(1'b0, 16'h01F0, 16'h0, 0, 1'b1);
    chk("R4 fast strobe code 2", low, 4);
    runCycle(1'b0, 16'h01F0, 16'h0, 0, 1'b0);
    chk("R8 fast recovery code 3", pre, 4);
    runCycle(1'b0, 16'h01F1, 16'h0, 0, 1'b0);
    chk("R5 non-data register compat", low, CS_LEN);
    chk("R9 no prefetch off data port", pf, 0);
  endtask

  task automatic testDriveSelect();
    ignoredReq("R3 ignored devhead write", 1'b1, 16'h0176, 16'h0010);
    runCycle(1'b0, 16'h01F0, 16'h0, 0, 1'b0);
    chk("R3 shadow kept after ignored write", low, 4);
    runCycle(1'b1, 16'h01F6, 16'h0010, 0, 1'b0);
    chk("R5 devhead write compat", low, CS_LEN);
    runCycle(1'b0, 16'h01F0, 16'h0, 0, 1'b0);
    chk("R3 drive 1 without fast bit", low, CS_LEN);
    setReg(16'hA317);
    runCycle(1'b0, 16'h01F0, 16'h0, 0, 1'b0);
    chk("R3 drive 1 nibble fast", low, 4);
    chk("R9 drive 1 prefetch clear", pf, 0);
    runCycle(1'b1, 16'h01F6, 16'h00A0, 0, 1'b0);
    runCycle(1'b0, 16'h01F0, 16'h0, 0, 1'b0);
    chk("R3 back to drive 0", {low[3:0], pf}, {4'd4, 1'b1});
  endtask

  task automatic testIordy();
    setReg(16'h8003);
    runCycle(1'b0, 16'h01F0, 16'h0, 6, 1'b0);
    chk("R6 fast IORDY stretch", low, 6);
    setReg(16'h8001);
    runCycle(1'b0, 16'h01F0, 16'h0, 100, 1'b0);
    chk("R6 fast IORDY ignored", low, 2);
    runCycle(1'b0, 16'h01F7, 16'h0, 12, 1'b0);
    chk("R6 compat IORDY stretch", low, 12);
  endtask

  task automatic testFastWrite();
    setReg(16'h8007);
    runCycle(1'b1, 16'h01F0, 16'h1234, 0, 1'b0);
    chk("R7 fast write data", wok, 1);
    chk("R4 fast write strobe", low, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPrimary();
    testSecondary();
    testFast();
    testDriveSelect();
    testIordy();
    testFastWrite();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule